// File: doc/BRIEF.md
# SD Host Command Issue Engine

This block starts SD card commands on behalf of a host. The host writes a 32-bit argument and then a 16-bit command word through a small register-write port. The command word carries a 6-bit command index and an 8-bit response-format code. The block decides whether the command may start. A command is refused while an earlier one is still outstanding. A command that expects a busy signal on the data line is also refused while the data path reports itself occupied.

An accepted command is handed to a card-side command engine over a level request. The engine answers with a completion pulse or an error pulse, and the completion carries a 128-bit response payload. On completion the block latches all four response words and raises a completion status bit. On error it raises an error status bit and emits a one-cycle request to soft-reset the command and data paths. If neither answer arrives within a programmable number of cycles, the block treats the command as failed. The host acknowledges status by writing ones to the bits it wants cleared.

Top module: `sd_cmd_issue`

## Requirements
- R1: After reset, status_o and resp_o are zero, and eng_req_o, cmd_inhibit_o and soft_rst_o are low.
- R2: A write to address 1 while cmd_inhibit_o is low starts a command, and the effect is visible after that clock edge. eng_req_o and cmd_inhibit_o go high. eng_index_o takes host_wdata[13:8] and eng_fmt_o takes host_wdata[7:0]; bits [15:14] are dropped. eng_arg_o takes the value last written to address 0. Response codes are 0x00 none, 0x1a short, 0x3a short with data, 0x1b short with busy, 0x02 short unchecked, and 0x09 long.
- R3: While cmd_inhibit_o is high, writes to address 1 are ignored, and a new write to address 0 does not alter eng_arg_o. eng_req_o stays high with unchanged fields.
- R4: A command whose format bits [1:0] are 2'b11 is refused while dat_inhibit_i is high: no request is raised and status is unchanged. Any other format is accepted whatever dat_inhibit_i is.
- R5: An eng_done_i pulse while a command is outstanding, with eng_err_i low, has four effects on the next edge: status_o bit 0 is set, eng_req_o and cmd_inhibit_o fall, and resp_o takes eng_resp_i. Word 0 of the response (least significant) sits in resp_o[31:0]. resp_o changes at no other time.
- R6: An eng_err_i pulse while a command is outstanding sets status_o bit 15 and ends the command. This holds even when eng_done_i is high in the same cycle. Bit 0 is not set, resp_o keeps its value, and soft_rst_o is high for exactly one cycle.
- R7: If no answer arrives, the error of R6 occurs exactly L clock edges after the edge that accepted the command. L is the limit written to address 3 (bits [15:0]) and resets to 1000.
- R8: A write to address 2 clears each status bit (0 and 15) whose data bit is 1 and leaves the others unchanged. A bit being set in the same cycle stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 2 | 0 argument, 1 command, 2 status clear, 3 timeout limit |
| host_wdata | input | 32 | Host write data |
| dat_inhibit_i | input | 1 | Data path occupied |
| eng_done_i | input | 1 | Engine completion pulse |
| eng_err_i | input | 1 | Engine error pulse |
| eng_resp_i | input | 128 | Engine response payload, word 0 in the low bits |
| cmd_inhibit_o | output | 1 | Command outstanding |
| status_o | output | 16 | Bit 0 complete, bit 15 error |
| resp_o | output | 128 | Latched response words |
| eng_req_o | output | 1 | Request to the engine, held until the outcome |
| eng_index_o | output | 6 | Command index of the outstanding command |
| eng_fmt_o | output | 8 | Response format of the outstanding command |
| eng_arg_o | output | 32 | Argument of the outstanding command |
| soft_rst_o | output | 1 | One-cycle command and data soft-reset request |

## Verification
A stuck or lost busy state shows within one edge. The request would fail to fall after an outcome, or a second command write would be taken. A timeout counter that is off by one shifts the error bit by a cycle; the bench looks for it on the exact edge, both at the reset limit and at a short one. A wrong priority between error and completion would show a complete bit or a changed response in the same cycle as the error. A wrong clear mask would show in the status read right after the write.

// File: rtl/sd_cmd_pkg.sv
// Shared constants for the SD command issue engine.
// Assumes a two-bit register address space on the host port.
package sd_cmd_pkg;
    localparam logic [1:0] ADR_ARG  = 2'd0;
    localparam logic [1:0] ADR_CMD  = 2'd1;
    localparam logic [1:0] ADR_CLR  = 2'd2;
    localparam logic [1:0] ADR_TLIM = 2'd3;

    localparam int ST_CMPL_BIT = 0;
    localparam int ST_ERR_BIT  = 15;

    localparam logic [7:0] RSP_NONE  = 8'h00;
    localparam logic [7:0] RSP_SHORT = 8'h1a;
    localparam logic [7:0] RSP_DATA  = 8'h3a;
    localparam logic [7:0] RSP_BUSY  = 8'h1b;
    localparam logic [7:0] RSP_NOCHK = 8'h02;
    localparam logic [7:0] RSP_LONG  = 8'h09;

    // True when the response format waits on a busy data line.
    function automatic logic fmt_needs_dat(input logic [7:0] fmt);
        return fmt[1:0] == 2'b11;
    endfunction
endpackage

// File: rtl/sd_cmd_gate.sv
// Decides whether a host command write may start a command.
// Assumes busy reflects an outstanding command on the same cycle.
module sd_cmd_gate
    import sd_cmd_pkg::*;
(
    input  logic        wr_cmd,
    input  logic [13:0] cmd_word,
    input  logic        busy,
    input  logic        dat_inhibit,
    output logic        accept,
    output logic [5:0]  index,
    output logic [7:0]  fmt
);
    // Split the command word and apply both inhibit rules.
    always_comb begin
        index  = cmd_word[13:8];
        fmt    = cmd_word[7:0];
        accept = wr_cmd && !busy && !(fmt_needs_dat(cmd_word[7:0]) && dat_inhibit);
    end
endmodule

// File: rtl/sd_cmd_seq.sv
// Holds the outstanding command, drives the engine request and times it out.
// Assumes engine pulses outside a command are spurious and ignores them.
module sd_cmd_seq #(
    parameter int ARG_W = 32,
    parameter int TO_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [5:0]       index_in,
    input  logic [7:0]       fmt_in,
    input  logic [ARG_W-1:0] arg_in,
    input  logic [TO_W-1:0]  tlim,
    input  logic             eng_done,
    input  logic             eng_err,
    output logic             busy,
    output logic [5:0]       index_q,
    output logic [7:0]       fmt_q,
    output logic [ARG_W-1:0] arg_q,
    output logic             fin_ok,
    output logic             fin_err,
    output logic             soft_rst
);
    logic [TO_W-1:0] cnt;
    logic [TO_W:0]   cnt_inc;
    logic            tmo;

    // Outcome decode: an error or timeout outranks completion.
    always_comb begin
        cnt_inc = {1'b0, cnt} + 1'b1;
        tmo     = busy && (cnt_inc >= {1'b0, tlim});
        fin_err = busy && (eng_err || tmo);
        fin_ok  = busy && eng_done && !eng_err && !tmo;
    end

    // Command state, field capture, wait counter and reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            cnt      <= '0;
            index_q  <= '0;
            fmt_q    <= '0;
            arg_q    <= '0;
            soft_rst <= 1'b0;
        end else begin
            soft_rst <= fin_err;
            if (accept) begin
                busy    <= 1'b1;
                cnt     <= '0;
                index_q <= index_in;
                fmt_q   <= fmt_in;
                arg_q   <= arg_in;
            end else if (fin_ok || fin_err) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else if (busy) begin
                cnt <= cnt_inc[TO_W-1:0];
            end
        end
    end

    AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !fin_ok && !fin_err |=> busy && $stable(index_q) && $stable(fmt_q) && $stable(arg_q)); // R3
    AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cnt == '0); // R7
endmodule

// File: rtl/sd_cmd_status.sv
// Status bits with write-one-to-clear and the latched response words.
// Assumes set and clear can coincide; set wins.
module sd_cmd_status
    import sd_cmd_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int RESP_WORDS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         fin_ok,
    input  logic                         fin_err,
    input  logic                         clr_we,
    input  logic [15:0]                  clr_mask,
    input  logic [WORD_W*RESP_WORDS-1:0] resp_in,
    output logic [15:0]                  status,
    output logic [WORD_W*RESP_WORDS-1:0] resp
);
    logic st_cmpl, st_err;

    // Status flags: clear by mask first, then apply new events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_cmpl <= 1'b0;
            st_err  <= 1'b0;
        end else begin
            st_cmpl <= (st_cmpl && !(clr_we && clr_mask[ST_CMPL_BIT])) || fin_ok;
            st_err  <= (st_err  && !(clr_we && clr_mask[ST_ERR_BIT]))  || fin_err;
        end
    end

    // Assemble the visible status word.
    always_comb begin
        status              = '0;
        status[ST_CMPL_BIT] = st_cmpl;
        status[ST_ERR_BIT]  = st_err;
    end

    // One latch per response word, low word first.
    for (genvar w = 0; w < RESP_WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                resp[w*WORD_W +: WORD_W] <= '0;
            else if (fin_ok)
                resp[w*WORD_W +: WORD_W] <= resp_in[w*WORD_W +: WORD_W];
        end
    end

    AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fin_ok |=> $stable(resp)); // R5
    AST_ERR_NO_CMPL: assert property (@(posedge clk) disable iff (!rst_n)
        fin_err && !st_cmpl |=> st_err && !st_cmpl); // R6
endmodule

// File: rtl/sd_cmd_issue.sv
// Top of the SD command issue engine: host registers, gate, sequencer, status.
// Assumes single-cycle host writes and single-cycle engine outcome pulses.
module sd_cmd_issue
    import sd_cmd_pkg::*;
#(
    parameter int ARG_W      = 32,
    parameter int WORD_W     = 32,
    parameter int RESP_WORDS = 4,
    parameter int TO_W       = 16,
    parameter int TO_RESET   = 1000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         host_we,
    input  logic [1:0]                   host_addr,
    input  logic [31:0]                  host_wdata,
    input  logic                         dat_inhibit_i,
    input  logic                         eng_done_i,
    input  logic                         eng_err_i,
    input  logic [WORD_W*RESP_WORDS-1:0] eng_resp_i,
    output logic                         cmd_inhibit_o,
    output logic [15:0]                  status_o,
    output logic [WORD_W*RESP_WORDS-1:0] resp_o,
    output logic                         eng_req_o,
    output logic [5:0]                   eng_index_o,
    output logic [7:0]                   eng_fmt_o,
    output logic [ARG_W-1:0]             eng_arg_o,
    output logic                         soft_rst_o
);
    localparam logic [TO_W-1:0] TLIM_INIT = TO_W'(TO_RESET);

    logic [ARG_W-1:0] arg_reg;
    logic [TO_W-1:0]  tlim_reg;
    logic             wr_cmd, accept, busy, fin_ok, fin_err;
    logic [5:0]       g_index;
    logic [7:0]       g_fmt;

    assign wr_cmd        = host_we && host_addr == ADR_CMD;
    assign cmd_inhibit_o = busy;
    assign eng_req_o     = busy;

    // Argument and timeout-limit registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arg_reg  <= '0;
            tlim_reg <= TLIM_INIT;
        end else if (host_we) begin
            if (host_addr == ADR_ARG)  arg_reg  <= host_wdata[ARG_W-1:0];
            if (host_addr == ADR_TLIM) tlim_reg <= host_wdata[TO_W-1:0];
        end
    end

    sd_cmd_gate u_gate (
        .wr_cmd      (wr_cmd),
        .cmd_word    (host_wdata[13:0]),
        .busy        (busy),
        .dat_inhibit (dat_inhibit_i),
        .accept      (accept),
        .index       (g_index),
        .fmt         (g_fmt)
    );

    sd_cmd_seq #(.ARG_W(ARG_W), .TO_W(TO_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .index_in (g_index),
        .fmt_in   (g_fmt),
        .arg_in   (arg_reg),
        .tlim     (tlim_reg),
        .eng_done (eng_done_i),
        .eng_err  (eng_err_i),
        .busy     (busy),
        .index_q  (eng_index_o),
        .fmt_q    (eng_fmt_o),
        .arg_q    (eng_arg_o),
        .fin_ok   (fin_ok),
        .fin_err  (fin_err),
        .soft_rst (soft_rst_o)
    );

    sd_cmd_status #(.WORD_W(WORD_W), .RESP_WORDS(RESP_WORDS)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .fin_ok   (fin_ok),
        .fin_err  (fin_err),
        .clr_we   (host_we && host_addr == ADR_CLR),
        .clr_mask (host_wdata[15:0]),
        .resp_in  (eng_resp_i),
        .status   (status_o),
        .resp     (resp_o)
    );

    AST_START_FROM_HOST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_req_o) |-> $past(host_we) && $past(host_addr) == ADR_CMD); // R2
    AST_RST_WITH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |-> status_o[ST_ERR_BIT]); // R6
    AST_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_inhibit_o && wr_cmd |=> $stable(eng_index_o)); // R3
endmodule

// File: tb/sd_cmd_issue_tb_top.sv
module sd_cmd_issue_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         host_we = 1'b0;
    logic [1:0]   host_addr = '0;
    logic [31:0]  host_wdata = '0;
    logic         dat_inhibit_i = 1'b0;
    logic         eng_done_i = 1'b0;
    logic         eng_err_i = 1'b0;
    logic [127:0] eng_resp_i = '0;
    logic         cmd_inhibit_o;
    logic [15:0]  status_o;
    logic [127:0] resp_o;
    logic         eng_req_o;
    logic [5:0]   eng_index_o;
    logic [7:0]   eng_fmt_o;
    logic [31:0]  eng_arg_o;
    logic         soft_rst_o;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sd_cmd_issue dut_i (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .dat_inhibit_i(dat_inhibit_i),
        .eng_done_i(eng_done_i), .eng_err_i(eng_err_i), .eng_resp_i(eng_resp_i),
        .cmd_inhibit_o(cmd_inhibit_o), .status_o(status_o), .resp_o(resp_o),
        .eng_req_o(eng_req_o), .eng_index_o(eng_index_o), .eng_fmt_o(eng_fmt_o),
        .eng_arg_o(eng_arg_o), .soft_rst_o(soft_rst_o)
    );

    // {command word, dat_inhibit, expect accepted}
    localparam logic [17:0] VEC [9] = '{
        {16'h0000, 1'b0, 1'b1},
        {16'h0102, 1'b0, 1'b1},
        {16'h0209, 1'b1, 1'b1},
        {16'h031a, 1'b1, 1'b1},
        {16'h071b, 1'b0, 1'b1},
        {16'h071b, 1'b1, 1'b0},
        {16'h113a, 1'b1, 1'b1},
        {16'h3f1b, 1'b1, 1'b0},
        {16'hc81a, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic hw(input logic [1:0] a, input logic [31:0] d);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        cyc();
        host_we = 1'b0;
    endtask

    task automatic done_pulse(input logic [127:0] r);
        eng_done_i = 1'b1; eng_resp_i = r;
        cyc();
        eng_done_i = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) cyc();
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [127:0] pat;
        logic [127:0] held;
        cyc();
        do_reset();
        // R1 reset state
        chk("R1 status", status_o, 0);
        chk("R1 resp", resp_o, 0);
        chk("R1 req/inhibit/rst", {eng_req_o, cmd_inhibit_o, soft_rst_o}, 0);

        // R7 default limit of 1000 cycles
        hw(2'd1, 32'h0000_051a);
        repeat (999) cyc();
        chk("R7 no error before default limit", status_o, 16'h0000);
        cyc();
        chk("R7 error at default limit", status_o, 16'h8000);
        chk("R7 soft reset with timeout", soft_rst_o, 1'b1);
        hw(2'd2, 32'h0000_8000);
        chk("R8 clear error", status_o, 0);

        // Vector table: R2, R4, R5, R8
        for (int i = 0; i < 9; i++) begin
            logic [15:0] cw;
            logic acc;
            cw = VEC[i][17:2];
            acc = VEC[i][0];
            hw(2'd0, 32'ha000_0000 + i);
            dat_inhibit_i = VEC[i][1];
            hw(2'd1, {16'h0, cw});
            dat_inhibit_i = 1'b0;
            chk("R4 accept decision", eng_req_o, acc);
            if (acc) begin
                chk("R2 index", eng_index_o, cw[13:8]);
                chk("R2 format", eng_fmt_o, cw[7:0]);
                chk("R2 argument", eng_arg_o, 32'ha000_0000 + i);
                chk("R2 inhibit", cmd_inhibit_o, 1'b1);
                pat = {32'h4000_0000 + i, 32'h3000_0000 + i, 32'h2000_0000 + i, 32'h1000_0000 + i};
                done_pulse(pat);
                chk("R5 complete bit", status_o, 16'h0001);
                chk("R5 response order", resp_o, pat);
                chk("R5 request drops", {eng_req_o, cmd_inhibit_o}, 2'b00);
                hw(2'd2, 32'h0000_0001);
                chk("R8 clear complete", status_o, 0);
            end else begin
                chk("R4 refused status", status_o, 0);
                chk("R4 refused inhibit", cmd_inhibit_o, 1'b0);
            end
        end

        // R3 writes ignored while busy
        hw(2'd0, 32'h1234_5678);
        hw(2'd1, 32'h0000_0d1a);
        hw(2'd0, 32'hdead_beef);
        hw(2'd1, 32'h0000_2a09);
        chk("R3 index kept", eng_index_o, 6'h0d);
        chk("R3 format kept", eng_fmt_o, 8'h1a);
        chk("R3 argument kept", eng_arg_o, 32'h1234_5678);
        chk("R3 still requesting", eng_req_o, 1'b1);

        // R6 error wins over simultaneous completion
        held = resp_o;
        eng_err_i = 1'b1; eng_done_i = 1'b1; eng_resp_i = {4{32'hffff_ffff}};
        cyc();
        eng_err_i = 1'b0; eng_done_i = 1'b0;
        chk("R6 error only", status_o, 16'h8000);
        chk("R6 response held", resp_o, held);
        chk("R6 soft reset pulse", soft_rst_o, 1'b1);
        chk("R6 command ended", cmd_inhibit_o, 1'b0);
        cyc();
        chk("R6 soft reset one cycle", soft_rst_o, 1'b0);

        // R8 mask selects bits
        hw(2'd2, 32'h0000_0001);
        chk("R8 unmasked bit kept", status_o, 16'h8000);
        hw(2'd2, 32'h0000_8000);
        chk("R8 masked bit cleared", status_o, 0);

        // R8 set wins over clear in the same cycle
        hw(2'd1, 32'h0000_0a1a);
        host_we = 1'b1; host_addr = 2'd2; host_wdata = 32'h0000_0001;
        eng_done_i = 1'b1; eng_resp_i = 128'h5;
        cyc();
        host_we = 1'b0; eng_done_i = 1'b0;
        chk("R8 set wins", status_o, 16'h0001);
        hw(2'd2, 32'h0000_0001);

        // R7 short limit of 5
        hw(2'd3, 32'd5);
        hw(2'd1, 32'h0000_0c1a);
        repeat (4) cyc();
        chk("R7 no error before limit", status_o, 0);
        chk("R7 still busy", cmd_inhibit_o, 1'b1);
        cyc();
        chk("R7 error at limit", status_o, 16'h8000);
        chk("R7 soft reset", soft_rst_o, 1'b1);
        chk("R7 response unchanged", resp_o, 128'h5);

        // R4 busy-format accepted when data is free after a refusal
        hw(2'd2, 32'h0000_8000);
        dat_inhibit_i = 1'b1;
        hw(2'd1, 32'h0000_071b);
        chk("R4 refused with data busy", eng_req_o, 1'b0);
        dat_inhibit_i = 1'b0;
        hw(2'd1, 32'h0000_071b);
        chk("R4 accepted with data free", eng_req_o, 1'b1);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule